// File: doc/BRIEF.md
# Debug Trigger Match Comparator

This block is one hardware breakpoint and watchpoint unit for a processor debug module. Software programs two registers through a small CSR port. The control word selects the comparison function, the operand source, an access-size filter, the privilege modes and the event kinds the trigger watches. It also holds a sticky hit flag. The compare word holds the value that each pipeline event is tested against.

Each cycle the pipeline can present one event. An event is an instruction fetch, a load or a store. It carries the current privilege mode, the access size, the lowest virtual address and the data or opcode. The unit decides whether the trigger fires for that event and reports the result on a registered output one clock later. In the same clock it sets the hit flag. Chaining with other triggers and the action taken on a hit belong to the surrounding logic.

Top module: `trig_match_unit`

## Requirements
- R1: After synchronous reset, the control word and the compare word read as 0 and `match_o` is 0.
- R2: A write with `csr_we`=1 updates the register chosen by `csr_sel` (0 = control, 1 = compare). `csr_rdata` presents the register chosen by `csr_sel` one clock after the edge that samples it. The control layout is: bit 0 execute enable, bit 1 load enable, bit 2 store enable, bit 3 machine-mode enable, bit 4 supervisor enable, bit 5 user enable, bit 6 virtual-supervisor enable, bit 7 virtual-user enable, bits 11:8 function code, bit 12 data select, bits 16:13 size filter, bit 17 hit. All other bits read 0.
- R3: A function code written outside {0,1,2,3,4,5,8,9,12,13} is stored as 0. Legal codes are stored unchanged.
- R4: A size filter written outside {0,1,2,3} is stored as 0. Value 5 is also kept when XLEN is at least 64.
- R5: An enable bit for a privilege mode that the parameters say is absent always reads 0. With the defaults, both virtual-mode bits are absent.
- R6: Function 0 fires when the compare value equals the compare word. Function 8 fires when function 0 would not.
- R7: Function 1 ignores every bit from bit 0 up to and including the lowest 0 bit of the compare word, and requires equality above it. Function 9 is its inverse.
- R8: Function 2 fires when the compare value is greater than or equal to the compare word. Function 3 fires when it is less. Both comparisons are unsigned.
- R9: Function 4 fires when (low half of value AND high half of word) equals the low half of the word. Function 5 does the same using the high half of the value. Functions 12 and 13 are their inverses.
- R10: With data select at 0, the compare value is `ev_addr`. With data select at 1, it is `ev_data`. In that case both the data and the compare word are cut to the low 8<<`ev_size` bits before the test.
- R11: Size filter 0 accepts any `ev_size`. Filters 1, 2, 3 and 5 accept only `ev_size` 0, 1, 2 and 3 respectively (8, 16, 32 and 64 bits).
- R12: The event kind must be enabled: `ev_kind` 0 execute, 1 load, 2 store, 3 never. The mode must be enabled: `ev_priv` 0 user, 1 supervisor, 3 machine, 4 virtual user, 5 virtual supervisor, other codes never.
- R13: `match_o` rises one clock after a qualifying event and sets the hit flag in the same clock. Software may clear or set the hit flag by a control write. A match in the same clock still sets the flag.
- R14: With `ev_valid` at 0, the unit never fires and the hit flag is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 control, 1 compare |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event kind: 0 execute, 1 load, 2 store |
| ev_priv | input | 3 | Privilege mode of the event |
| ev_size | input | 2 | Access size as log2 of bytes |
| ev_addr | input | XLEN | Lowest virtual address of the access |
| ev_data | input | XLEN | Data loaded or stored, or opcode |
| match_o | output | 1 | Registered trigger match |

## Verification
The bound checker watches the control word on every cycle. It checks that only legal function codes and size filters are held and that absent-mode bits stay 0. It checks that every match follows a valid event of a real kind, that every match coincides with a set hit flag, and that the hit flag stays set unless software writes the control word. The arithmetic of each comparison function, the operand cut for data compares, and the size, mode and kind filters can only be shown by the bench scenarios. These use hand-picked vectors and randomized operands that are checked against an independent model of the functions.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int CTRL_W = 18;

  typedef struct packed {
    logic       hit;
    logic [3:0] szf;
    logic       sel;
    logic [3:0] func;
    logic       en_vu;
    logic       en_vs;
    logic       en_u;
    logic       en_s;
    logic       en_m;
    logic       en_store;
    logic       en_load;
    logic       en_exec;
  } trig_ctrl_t;

  localparam logic [1:0] KIND_EXEC  = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [2:0] PRIV_U  = 3'd0;
  localparam logic [2:0] PRIV_S  = 3'd1;
  localparam logic [2:0] PRIV_M  = 3'd3;
  localparam logic [2:0] PRIV_VU = 3'd4;
  localparam logic [2:0] PRIV_VS = 3'd5;

  function automatic logic func_legal(input logic [3:0] f);
    case (f)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
      4'd8, 4'd9, 4'd12, 4'd13: func_legal = 1'b1;
      default:                  func_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trig_csr.sv
module trig_csr
  import trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit HAS_S    = 1'b1,
  parameter bit HAS_U    = 1'b1,
  parameter bit HAS_VIRT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            sel_cmp,
  input  logic [XLEN-1:0] wdata,
  input  logic            set_hit,
  output trig_ctrl_t      ctrl,
  output logic [XLEN-1:0] cmp_word
);

  localparam bit WIDE = (XLEN >= 64);

  trig_ctrl_t wr_legal;
  trig_ctrl_t ctrl_next;

  always_comb begin
    wr_legal = trig_ctrl_t'(wdata[CTRL_W-1:0]);
    if (!func_legal(wr_legal.func)) wr_legal.func = 4'd0;
    case (wr_legal.szf)
      4'd0, 4'd1, 4'd2, 4'd3: ;
      4'd5:    if (!WIDE) wr_legal.szf = 4'd0;
      default: wr_legal.szf = 4'd0;
    endcase
    if (!HAS_S)    wr_legal.en_s  = 1'b0;
    if (!HAS_U)    wr_legal.en_u  = 1'b0;
    if (!HAS_VIRT) begin
      wr_legal.en_vs = 1'b0;
      wr_legal.en_vu = 1'b0;
    end
  end

  always_comb begin
    ctrl_next = ctrl;
    if (we && !sel_cmp) ctrl_next = wr_legal;
    ctrl_next.hit = ctrl_next.hit | set_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      cmp_word <= '0;
    end else begin
      ctrl <= ctrl_next;
      if (we && sel_cmp) cmp_word <= wdata;
    end
  end

endmodule

// File: rtl/trig_operand.sv
module trig_operand #(
  parameter int XLEN = 32
) (
  input  logic            sel_data,
  input  logic [1:0]      ev_size,
  input  logic [XLEN-1:0] ev_addr,
  input  logic [XLEN-1:0] ev_data,
  input  logic [XLEN-1:0] cmp_word,
  output logic [XLEN-1:0] val,
  output logic [XLEN-1:0] ref_word
);

  logic [XLEN-1:0] size_mask;
  logic [31:0]     nbits;

  assign nbits = 32'd8 << ev_size;

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      size_mask[i] = (i < int'(nbits));
    end
  end

  assign val      = sel_data ? (ev_data & size_mask) : ev_addr;
  assign ref_word = sel_data ? (cmp_word & size_mask) : cmp_word;

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      func,
  input  logic [XLEN-1:0] val,
  input  logic [XLEN-1:0] ref_word,
  output logic            hit
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] ign;
  logic eq, napot, ge, lt, lo_mask, hi_mask;

  // ones from bit 0 through the lowest zero bit of the compare word
  assign ign     = ref_word ^ (ref_word + {{(XLEN-1){1'b0}}, 1'b1});
  assign eq      = (val == ref_word);
  assign napot   = (((val ^ ref_word) & ~ign) == '0);
  assign ge      = (val >= ref_word);
  assign lt      = (val < ref_word);
  assign lo_mask = ((val[HALF-1:0] & ref_word[XLEN-1:HALF]) == ref_word[HALF-1:0]);
  assign hi_mask = ((val[XLEN-1:HALF] & ref_word[XLEN-1:HALF]) == ref_word[HALF-1:0]);

  always_comb begin
    case (func)
      4'd0:    hit = eq;
      4'd1:    hit = napot;
      4'd2:    hit = ge;
      4'd3:    hit = lt;
      4'd4:    hit = lo_mask;
      4'd5:    hit = hi_mask;
      4'd8:    hit = !eq;
      4'd9:    hit = !napot;
      4'd12:   hit = !lo_mask;
      4'd13:   hit = !hi_mask;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/trig_qualify.sv
module trig_qualify
  import trig_pkg::*;
(
  input  logic [7:0] en,
  input  logic [3:0] szf,
  input  logic       ev_valid,
  input  logic [1:0] ev_kind,
  input  logic [2:0] ev_priv,
  input  logic [1:0] ev_size,
  output logic       ok
);

  logic kind_ok, priv_ok, size_ok;

  always_comb begin
    case (ev_kind)
      KIND_EXEC:  kind_ok = en[0];
      KIND_LOAD:  kind_ok = en[1];
      KIND_STORE: kind_ok = en[2];
      default:    kind_ok = 1'b0;
    endcase
    case (ev_priv)
      PRIV_M:  priv_ok = en[3];
      PRIV_S:  priv_ok = en[4];
      PRIV_U:  priv_ok = en[5];
      PRIV_VS: priv_ok = en[6];
      PRIV_VU: priv_ok = en[7];
      default: priv_ok = 1'b0;
    endcase
    case (szf)
      4'd0:    size_ok = 1'b1;
      4'd1:    size_ok = (ev_size == 2'd0);
      4'd2:    size_ok = (ev_size == 2'd1);
      4'd3:    size_ok = (ev_size == 2'd2);
      4'd5:    size_ok = (ev_size == 2'd3);
      default: size_ok = 1'b0;
    endcase
  end

  assign ok = ev_valid && kind_ok && priv_ok && size_ok;

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit HAS_S    = 1'b1,
  parameter bit HAS_U    = 1'b1,
  parameter bit HAS_VIRT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_we,
  input  logic            csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            ev_valid,
  input  logic [1:0]      ev_kind,
  input  logic [2:0]      ev_priv,
  input  logic [1:0]      ev_size,
  input  logic [XLEN-1:0] ev_addr,
  input  logic [XLEN-1:0] ev_data,
  output logic            match_o
);

  trig_ctrl_t      ctrl_q;
  logic [XLEN-1:0] cmp_q;
  logic [XLEN-1:0] val, ref_word;
  logic            qual_ok, func_hit, match_now;

  trig_csr #(.XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_VIRT(HAS_VIRT)) u_csr (
    .clk(clk), .rst(rst), .we(csr_we), .sel_cmp(csr_sel), .wdata(csr_wdata),
    .set_hit(match_now), .ctrl(ctrl_q), .cmp_word(cmp_q)
  );

  trig_operand #(.XLEN(XLEN)) u_opnd (
    .sel_data(ctrl_q.sel), .ev_size(ev_size), .ev_addr(ev_addr), .ev_data(ev_data),
    .cmp_word(cmp_q), .val(val), .ref_word(ref_word)
  );

  trig_cmp #(.XLEN(XLEN)) u_cmp (
    .func(ctrl_q.func), .val(val), .ref_word(ref_word), .hit(func_hit)
  );

  trig_qualify u_qual (
    .en({ctrl_q.en_vu, ctrl_q.en_vs, ctrl_q.en_u, ctrl_q.en_s,
         ctrl_q.en_m, ctrl_q.en_store, ctrl_q.en_load, ctrl_q.en_exec}),
    .szf(ctrl_q.szf), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_priv(ev_priv), .ev_size(ev_size), .ok(qual_ok)
  );

  assign match_now = qual_ok && func_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o   <= 1'b0;
      csr_rdata <= '0;
    end else begin
      match_o   <= match_now;
      csr_rdata <= csr_sel ? cmp_q : {{(XLEN-CTRL_W){1'b0}}, ctrl_q};
    end
  end

endmodule

// File: rtl/trig_match_sva.sv
module trig_match_sva
  import trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit HAS_VIRT = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       csr_we,
  input logic       ev_valid,
  input logic [1:0] ev_kind,
  input logic       match_o,
  input logic       hit,
  input logic [3:0] func,
  input logic [3:0] szf,
  input logic       en_vs,
  input logic       en_vu
);

  localparam bit WIDE = (XLEN >= 64);

  p_valid_needed_r14: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(ev_valid));

  p_no_kind3_r12: assert property (@(posedge clk) disable iff (rst)
    match_o |-> ($past(ev_kind) != 2'd3));

  p_hit_with_match_r13: assert property (@(posedge clk) disable iff (rst)
    match_o |-> hit);

  p_hit_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    (hit && !csr_we) |=> hit);

  p_func_legal_r3: assert property (@(posedge clk) disable iff (rst)
    func_legal(func));

  p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (szf <= 4'd3) || (WIDE && szf == 4'd5));

  p_virt_zero_r5: assert property (@(posedge clk) disable iff (rst)
    HAS_VIRT || (!en_vs && !en_vu));

endmodule

bind trig_match_unit trig_match_sva #(.XLEN(XLEN), .HAS_VIRT(HAS_VIRT)) u_sva (
  .clk(clk), .rst(rst), .csr_we(csr_we), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .match_o(match_o), .hit(ctrl_q.hit), .func(ctrl_q.func), .szf(ctrl_q.szf),
  .en_vs(ctrl_q.en_vs), .en_vu(ctrl_q.en_vu)
);

// File: tb/trig_match_unit_tb.sv
module trig_match_unit_tb;

  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_we = 1'b0, csr_sel = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0, csr_rdata;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [2:0] ev_priv = 3'd3;
  logic [1:0] ev_size = 2'd2;
  logic [XLEN-1:0] ev_addr = '0, ev_data = '0;
  logic match_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trig_match_unit u_dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_priv(ev_priv),
    .ev_size(ev_size), .ev_addr(ev_addr), .ev_data(ev_data), .match_o(match_o)
  );

  typedef struct packed {
    logic [3:0]  func;
    logic        sel;
    logic [3:0]  szf;
    logic [1:0]  kind;
    logic [2:0]  priv;
    logic [1:0]  evsz;
    logic [31:0] t2;
    logic [31:0] addr;
    logic [31:0] data;
    logic        exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_1000, 32'h0000_1000, 32'h0, 1'b1}, // R6
    '{4'd0,  1'b0, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_1000, 32'h0000_1004, 32'h0, 1'b0}, // R6
    '{4'd8,  1'b0, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_1000, 32'h0000_1004, 32'h0, 1'b1}, // R6
    '{4'd1,  1'b0, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_10FF, 32'h0000_11AB, 32'h0, 1'b1}, // R7
    '{4'd1,  1'b0, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_10FF, 32'h0000_1200, 32'h0, 1'b0}, // R7
    '{4'd9,  1'b0, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_10FF, 32'h0000_1200, 32'h0, 1'b1}, // R7
    '{4'd2,  1'b0, 4'd0, 2'd2, 3'd3, 2'd2, 32'h0000_8000, 32'h0000_8000, 32'h0, 1'b1}, // R8
    '{4'd2,  1'b0, 4'd0, 2'd2, 3'd3, 2'd2, 32'h0000_8000, 32'h0000_7FFF, 32'h0, 1'b0}, // R8
    '{4'd3,  1'b0, 4'd0, 2'd2, 3'd3, 2'd2, 32'h0000_8000, 32'h0000_7FFF, 32'h0, 1'b1}, // R8
    '{4'd3,  1'b0, 4'd0, 2'd2, 3'd3, 2'd2, 32'h0000_8000, 32'hFFFF_0000, 32'h0, 1'b0}, // R8
    '{4'd4,  1'b0, 4'd0, 2'd0, 3'd3, 2'd2, 32'h00FF_0034, 32'hABCD_1234, 32'h0, 1'b1}, // R9
    '{4'd5,  1'b0, 4'd0, 2'd0, 3'd3, 2'd2, 32'h00FF_0034, 32'h5634_0000, 32'h0, 1'b1}, // R9
    '{4'd12, 1'b0, 4'd0, 2'd0, 3'd3, 2'd2, 32'h00FF_0034, 32'hABCD_1234, 32'h0, 1'b0}, // R9
    '{4'd13, 1'b0, 4'd0, 2'd0, 3'd3, 2'd2, 32'h00FF_0034, 32'h5635_0000, 32'h0, 1'b1}, // R9
    '{4'd0,  1'b1, 4'd0, 2'd1, 3'd3, 2'd0, 32'h0000_0077, 32'h0,         32'hABCD_EF77, 1'b1}, // R10
    '{4'd0,  1'b1, 4'd0, 2'd2, 3'd3, 2'd0, 32'hFFFF_FF77, 32'h0,         32'h0000_0077, 1'b1}, // R10
    '{4'd0,  1'b1, 4'd0, 2'd1, 3'd3, 2'd2, 32'h0000_1000, 32'h0000_1000, 32'h0000_0005, 1'b0}, // R10
    '{4'd0,  1'b0, 4'd1, 2'd1, 3'd3, 2'd2, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b0}, // R11
    '{4'd0,  1'b0, 4'd3, 2'd1, 3'd3, 2'd2, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b1}, // R11
    '{4'd0,  1'b0, 4'd2, 2'd1, 3'd3, 2'd1, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b1}, // R11
    '{4'd0,  1'b0, 4'd0, 2'd1, 3'd0, 2'd2, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b1}, // R12
    '{4'd0,  1'b0, 4'd0, 2'd1, 3'd5, 2'd2, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b0}, // R12
    '{4'd0,  1'b0, 4'd0, 2'd3, 3'd3, 2'd2, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b0}, // R12
    '{4'd0,  1'b0, 4'd0, 2'd1, 3'd2, 2'd2, 32'h0000_0040, 32'h0000_0040, 32'h0, 1'b0}  // R12
  };

  function automatic logic [31:0] mk_ctrl(input logic [3:0] f, input logic s,
                                          input logic [3:0] z, input logic [7:0] en,
                                          input logic h);
    mk_ctrl = {14'b0, h, z, s, f, en};
  endfunction

  function automatic logic ref_match(input logic [3:0] f, input logic s, input logic [1:0] sz,
                                     input logic [31:0] t2, input logic [31:0] a,
                                     input logic [31:0] d);
    logic [31:0] m, v, t;
    int lz;
    logic eq, np, lo, hi;
    m = '0;
    for (int i = 0; i < 32; i++) if (i < (8 << sz)) m[i] = 1'b1;
    v = s ? (d & m) : a;
    t = s ? (t2 & m) : t2;
    lz = 32;
    for (int i = 31; i >= 0; i--) if (!t[i]) lz = i;
    np = 1'b1;
    for (int i = 0; i < 32; i++) if (i > lz && v[i] != t[i]) np = 1'b0;
    eq = (v == t);
    lo = ((v[15:0] & t[31:16]) == t[15:0]);
    hi = ((v[31:16] & t[31:16]) == t[15:0]);
    case (f)
      4'd0: ref_match = eq;   4'd8:  ref_match = !eq;
      4'd1: ref_match = np;   4'd9:  ref_match = !np;
      4'd2: ref_match = (v >= t);
      4'd3: ref_match = (v < t);
      4'd4: ref_match = lo;   4'd12: ref_match = !lo;
      4'd5: ref_match = hi;   4'd13: ref_match = !hi;
      default: ref_match = 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] d);
    csr_sel = s;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic fire(input logic v, input logic [1:0] k, input logic [2:0] p,
                      input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    ev_valid = v; ev_kind = k; ev_priv = p; ev_size = sz; ev_addr = a; ev_data = d;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [3:0] codes [10];
    codes = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd12, 4'd13};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 match", {31'b0, match_o}, 32'h0);
    rd(1'b0, r); chk("R1 ctrl", r, 32'h0);
    rd(1'b1, r); chk("R1 cmp", r, 32'h0);

    // R2 readback and field layout
    wr(1'b1, 32'hDEAD_BEEF);
    rd(1'b1, r); chk("R2 cmp", r, 32'hDEAD_BEEF);
    wr(1'b0, 32'hFFFC_0000 | mk_ctrl(4'd3, 1'b1, 4'd2, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R2 ctrl", r, mk_ctrl(4'd3, 1'b1, 4'd2, 8'h3F, 1'b0));

    // R3 function legalisation
    wr(1'b0, mk_ctrl(4'd6, 1'b0, 4'd0, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R3 code6", {28'b0, r[11:8]}, 32'd0);
    wr(1'b0, mk_ctrl(4'd15, 1'b0, 4'd0, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R3 code15", {28'b0, r[11:8]}, 32'd0);
    wr(1'b0, mk_ctrl(4'd13, 1'b0, 4'd0, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R3 code13", {28'b0, r[11:8]}, 32'd13);

    // R4 size legalisation
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd4, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R4 size4", {28'b0, r[16:13]}, 32'd0);
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd5, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R4 size5", {28'b0, r[16:13]}, 32'd0);
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd3, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R4 size3", {28'b0, r[16:13]}, 32'd3);

    // R5 absent virtual modes
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'hFF, 1'b0));
    rd(1'b0, r); chk("R5 virt bits", {30'b0, r[7:6]}, 32'd0);

    // table walk, R6..R12
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, mk_ctrl(VECS[i].func, VECS[i].sel, VECS[i].szf, 8'hFF, 1'b0));
      wr(1'b1, VECS[i].t2);
      fire(1'b1, VECS[i].kind, VECS[i].priv, VECS[i].evsz, VECS[i].addr, VECS[i].data);
      chk($sformatf("R6-12 table vector %0d", i), {31'b0, match_o}, {31'b0, VECS[i].exp});
    end

    // R12 kind enables: execute only, machine mode
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'h09, 1'b0));
    wr(1'b1, 32'h0000_2000);
    fire(1'b1, 2'd1, 3'd3, 2'd2, 32'h0000_2000, 32'h0);
    chk("R12 load disabled", {31'b0, match_o}, 32'h0);
    fire(1'b1, 2'd0, 3'd3, 2'd2, 32'h0000_2000, 32'h0);
    chk("R12 exec enabled", {31'b0, match_o}, 32'h1);
    // R12 mode enables: supervisor and user only
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'h37, 1'b0));
    fire(1'b1, 2'd2, 3'd3, 2'd2, 32'h0000_2000, 32'h0);
    chk("R12 machine disabled", {31'b0, match_o}, 32'h0);
    fire(1'b1, 2'd2, 3'd1, 2'd2, 32'h0000_2000, 32'h0);
    chk("R12 supervisor enabled", {31'b0, match_o}, 32'h1);

    // R14 invalid event ignored
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'h3F, 1'b0));
    fire(1'b0, 2'd1, 3'd3, 2'd2, 32'h0000_2000, 32'h0);
    chk("R14 no match", {31'b0, match_o}, 32'h0);
    rd(1'b0, r); chk("R14 hit unchanged", {31'b0, r[17]}, 32'h0);

    // R13 hit flag
    fire(1'b1, 2'd1, 3'd3, 2'd2, 32'h0000_2000, 32'h0);
    chk("R13 match pulse", {31'b0, match_o}, 32'h1);
    rd(1'b0, r); chk("R13 hit set", {31'b0, r[17]}, 32'h1);
    chk("R13 match one cycle", {31'b0, match_o}, 32'h0);
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'h3F, 1'b0));
    rd(1'b0, r); chk("R13 sw clear", {31'b0, r[17]}, 32'h0);
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'h3F, 1'b1));
    rd(1'b0, r); chk("R13 sw set", {31'b0, r[17]}, 32'h1);
    ev_valid = 1'b1; ev_kind = 2'd1; ev_priv = 3'd3; ev_size = 2'd2; ev_addr = 32'h0000_2000;
    wr(1'b0, mk_ctrl(4'd0, 1'b0, 4'd0, 8'h3F, 1'b0));
    ev_valid = 1'b0;
    rd(1'b0, r); chk("R13 match beats clear", {31'b0, r[17]}, 32'h1);

    // random operands against the reference model, R6..R10
    for (int c = 0; c < 10; c++) begin
      for (int k = 0; k < 12; k++) begin
        logic [31:0] t2v, av, dv;
        logic sv;
        logic [1:0] szv;
        t2v = $urandom;
        av  = (k % 2 == 0) ? (t2v ^ ($urandom & 32'h0000_00FF)) : $urandom;
        dv  = (k % 3 == 0) ? t2v : $urandom;
        sv  = k[2];
        szv = 2'($urandom_range(0, 2));
        wr(1'b0, mk_ctrl(codes[c], sv, 4'd0, 8'h3F, 1'b0));
        wr(1'b1, t2v);
        fire(1'b1, 2'd1, 3'd3, szv, av, dv);
        chk($sformatf("R6-R10 random code %0d", codes[c]), {31'b0, match_o},
            {31'b0, ref_match(codes[c], sv, szv, t2v, av, dv)});
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule